// File: doc/BRIEF.md
# Conditional Test Evaluation Unit

This block answers one question for a processor's conditional instructions: given a 5-bit condition code, is the condition satisfied right now? It takes the arithmetic flags (negative, zero, logical overflow, mathematical overflow), the outcome flags of a bit-I/O compare, the parity and minus-one flags of a bit-manipulation unit, and a random bit supplied by an external sequence generator. It answers in the same cycle on a single result line.

Some conditions have side effects. The block holds two 16-bit two's-complement loop counters. A counter test compares the counter's sign before the update, and the tested counter then steps up by one at the next clock edge. A random-bit test raises a one-cycle advance request toward the generator. Either counter can be loaded through a write port. When a load and an increment hit the same counter in the same cycle, the load wins.

A test only counts when `cond_valid` is high. With `cond_valid` low the result is false and there are no side effects.

Top module: `cond_eval_unit`

## Requirements
- R1: Codes 2..7 test the negative and zero flags: 2 passes when negative is clear, 3 when negative is set, 4 when zero is set, 5 when zero is clear, 6 when both are clear, and 7 when either is set.
- R2: Codes 8/9 pass when the logical overflow flag is set/clear, and codes 10/11 pass when the mathematical overflow flag is set/clear.
- R3: Codes 12/13 pass when counter 0's bit 15 is clear/set, and codes 14/15 do the same for counter 1. In every case the value used is the one held before that cycle's update.
- R4: An evaluated counter test adds one to the tested counter at the next clock edge, wrapping modulo 2^16. The other counter is untouched.
- R5: A counter changes only through an evaluated test of it or a load of it. With `cond_valid` low, a counter code has no effect.
- R6: With `cnt_wr_en` high, the counter chosen by `cnt_wr_sel` (0 or 1) takes `cnt_wr_data` at the next edge, even if the same cycle evaluates a test of that counter.
- R7: Code 16 passes when `rnd_bit` is 1 and code 17 passes when it is 0. `rnd_advance` is high exactly in the cycles that evaluate code 16 or 17.
- R8: Code 0 always passes and code 1 never passes.
- R9: Codes 18, 19, 20 and 21 return `bio_all`, `bio_none`, `bio_some` and `bio_notall` respectively.
- R10: Codes 22/23 pass on `bmu_odd` set/clear, and codes 24/25 pass on `bmu_m1` set/clear.
- R11: Codes 26..31 evaluate false, raise no advance request and change no counter.
- R12: During reset both counters read 0. While `cond_valid` is low, `cond_true` and `rnd_advance` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_valid | input | 1 | A condition is being evaluated this cycle |
| cond_sel | input | 5 | Condition code |
| flag_neg | input | 1 | Arithmetic result negative |
| flag_zero | input | 1 | Arithmetic result zero |
| flag_lovf | input | 1 | Logical overflow |
| flag_movf | input | 1 | Mathematical overflow |
| bio_all | input | 1 | Every tested bit-I/O input matched |
| bio_none | input | 1 | No tested bit-I/O input matched |
| bio_some | input | 1 | At least one tested input matched |
| bio_notall | input | 1 | At least one tested input missed |
| bmu_odd | input | 1 | Bit-manipulation result has odd parity |
| bmu_m1 | input | 1 | Bit-manipulation result is minus one |
| rnd_bit | input | 1 | Current random bit |
| cnt_wr_en | input | 1 | Load a counter |
| cnt_wr_sel | input | 1 | Counter to load |
| cnt_wr_data | input | 16 | Load value |
| cond_true | output | 1 | Condition result |
| rnd_advance | output | 1 | Request to step the random generator |
| cnt0 | output | 16 | Counter 0 value |
| cnt1 | output | 16 | Counter 1 value |

## Verification
The hardest case to reach from the ports is a counter sitting at its sign boundary when a test of it and a load of it arrive in the same cycle. Random counter values almost never land on 0x7FFF or 0xFFFF, and random writes rarely collide with a test of the same counter.

The stimulus handles this in two ways. Directed steps first load values next to the boundary and then test across it, including a test that collides with a load. The random phase then biases its loads toward those boundary values, and it mixes writes with all 32 codes while `cond_valid` toggles.

// File: rtl/cond_eval_pkg.sv
`timescale 1ns/1ps
package cond_eval_pkg;

    localparam int CC_W      = 5;
    localparam int NUM_CNT   = 2;
    localparam int CNT_IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    typedef enum logic [CC_W-1:0] {
        CC_ALWAYS      = 5'd0,
        CC_NEVER       = 5'd1,
        CC_NONNEG      = 5'd2,
        CC_NEG         = 5'd3,
        CC_ZERO        = 5'd4,
        CC_NONZERO     = 5'd5,
        CC_POS         = 5'd6,
        CC_NONPOS      = 5'd7,
        CC_LOVF_SET    = 5'd8,
        CC_LOVF_CLR    = 5'd9,
        CC_MOVF_SET    = 5'd10,
        CC_MOVF_CLR    = 5'd11,
        CC_CNT0_NONNEG = 5'd12,
        CC_CNT0_NEG    = 5'd13,
        CC_CNT1_NONNEG = 5'd14,
        CC_CNT1_NEG    = 5'd15,
        CC_RND_ONE     = 5'd16,
        CC_RND_ZERO    = 5'd17,
        CC_BIO_ALL     = 5'd18,
        CC_BIO_NONE    = 5'd19,
        CC_BIO_SOME    = 5'd20,
        CC_BIO_NOTALL  = 5'd21,
        CC_PAR_ODD     = 5'd22,
        CC_PAR_EVEN    = 5'd23,
        CC_BMU_M1      = 5'd24,
        CC_BMU_NOTM1   = 5'd25
    } cc_code_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic lovf;
        logic movf;
        logic bio_all;
        logic bio_none;
        logic bio_some;
        logic bio_notall;
        logic bmu_odd;
        logic bmu_m1;
        logic rnd;
    } cc_flags_t;

endpackage

// File: rtl/cev_cond_decode.sv
`timescale 1ns/1ps
module cev_cond_decode
    import cond_eval_pkg::*;
(
    input  logic [CC_W-1:0]    code_i,
    input  logic               valid_i,
    input  cc_flags_t          flags_i,
    input  logic [NUM_CNT-1:0] cnt_neg_i,
    output logic               hit_o,
    output logic [NUM_CNT-1:0] inc_o,
    output logic               rnd_req_o
);

    logic               hit_raw;
    logic [NUM_CNT-1:0] inc_raw;
    logic               rnd_raw;

    always_comb begin
        hit_raw = 1'b0;
        inc_raw = '0;
        rnd_raw = 1'b0;
        case (cc_code_e'(code_i))
            CC_ALWAYS:      hit_raw = 1'b1;
            CC_NEVER:       hit_raw = 1'b0;
            CC_NONNEG:      hit_raw = !flags_i.neg;
            CC_NEG:         hit_raw = flags_i.neg;
            CC_ZERO:        hit_raw = flags_i.zero;
            CC_NONZERO:     hit_raw = !flags_i.zero;
            CC_POS:         hit_raw = !(flags_i.neg || flags_i.zero);
            CC_NONPOS:      hit_raw = flags_i.neg || flags_i.zero;
            CC_LOVF_SET:    hit_raw = flags_i.lovf;
            CC_LOVF_CLR:    hit_raw = !flags_i.lovf;
            CC_MOVF_SET:    hit_raw = flags_i.movf;
            CC_MOVF_CLR:    hit_raw = !flags_i.movf;
            CC_CNT0_NONNEG: begin hit_raw = !cnt_neg_i[0]; inc_raw[0] = 1'b1; end
            CC_CNT0_NEG:    begin hit_raw = cnt_neg_i[0];  inc_raw[0] = 1'b1; end
            CC_CNT1_NONNEG: begin hit_raw = !cnt_neg_i[1]; inc_raw[1] = 1'b1; end
            CC_CNT1_NEG:    begin hit_raw = cnt_neg_i[1];  inc_raw[1] = 1'b1; end
            CC_RND_ONE:     begin hit_raw = flags_i.rnd;   rnd_raw = 1'b1; end
            CC_RND_ZERO:    begin hit_raw = !flags_i.rnd;  rnd_raw = 1'b1; end
            CC_BIO_ALL:     hit_raw = flags_i.bio_all;
            CC_BIO_NONE:    hit_raw = flags_i.bio_none;
            CC_BIO_SOME:    hit_raw = flags_i.bio_some;
            CC_BIO_NOTALL:  hit_raw = flags_i.bio_notall;
            CC_PAR_ODD:     hit_raw = flags_i.bmu_odd;
            CC_PAR_EVEN:    hit_raw = !flags_i.bmu_odd;
            CC_BMU_M1:      hit_raw = flags_i.bmu_m1;
            CC_BMU_NOTM1:   hit_raw = !flags_i.bmu_m1;
            default:        hit_raw = 1'b0;
        endcase
    end

    // every result and side effect is gated by the evaluate strobe
    assign hit_o     = valid_i && hit_raw;
    assign inc_o     = valid_i ? inc_raw : '0;
    assign rnd_req_o = valid_i && rnd_raw;

endmodule

// File: rtl/cev_loop_counter.sv
`timescale 1ns/1ps
module cev_loop_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_data_i,
    output logic [CNT_W-1:0] val_o
);

    logic [CNT_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (ld_i) begin
            val_q <= ld_data_i;
        end else if (inc_i) begin
            val_q <= val_q + CNT_W'(1);
        end
    end

    assign val_o = val_q;

    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (val_o == $past(ld_data_i)));

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i) |=> (val_o == $past(val_o) + CNT_W'(1)));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i) |=> $stable(val_o));

endmodule

// File: rtl/cond_eval_unit.sv
`timescale 1ns/1ps
module cond_eval_unit
    import cond_eval_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cond_valid,
    input  logic [CC_W-1:0]      cond_sel,
    input  logic                 flag_neg,
    input  logic                 flag_zero,
    input  logic                 flag_lovf,
    input  logic                 flag_movf,
    input  logic                 bio_all,
    input  logic                 bio_none,
    input  logic                 bio_some,
    input  logic                 bio_notall,
    input  logic                 bmu_odd,
    input  logic                 bmu_m1,
    input  logic                 rnd_bit,
    input  logic                 cnt_wr_en,
    input  logic [CNT_IDX_W-1:0] cnt_wr_sel,
    input  logic [CNT_W-1:0]     cnt_wr_data,
    output logic                 cond_true,
    output logic                 rnd_advance,
    output logic [CNT_W-1:0]     cnt0,
    output logic [CNT_W-1:0]     cnt1
);

    cc_flags_t          flags;
    logic [NUM_CNT-1:0] inc_req;
    logic [NUM_CNT-1:0] cnt_neg;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    assign flags = '{neg: flag_neg, zero: flag_zero, lovf: flag_lovf,
                     movf: flag_movf, bio_all: bio_all, bio_none: bio_none,
                     bio_some: bio_some, bio_notall: bio_notall,
                     bmu_odd: bmu_odd, bmu_m1: bmu_m1, rnd: rnd_bit};

    cev_cond_decode u_decode (
        .code_i    (cond_sel),
        .valid_i   (cond_valid),
        .flags_i   (flags),
        .cnt_neg_i (cnt_neg),
        .hit_o     (cond_true),
        .inc_o     (inc_req),
        .rnd_req_o (rnd_advance)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        logic ld_here;
        assign ld_here     = cnt_wr_en && (cnt_wr_sel == CNT_IDX_W'(gi));
        assign cnt_neg[gi] = cnt_val[gi][CNT_W-1];

        cev_loop_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc_req[gi]),
            .ld_i      (ld_here),
            .ld_data_i (cnt_wr_data),
            .val_o     (cnt_val[gi])
        );
    end

    assign cnt0 = cnt_val[0];
    assign cnt1 = cnt_val[1];

    p_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_valid |-> (!cond_true && !rnd_advance));

    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel == CC_ALWAYS) |-> cond_true);

    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel == CC_NEVER) |-> !cond_true);

    p_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel == CC_POS) |-> (cond_true == (!flag_neg && !flag_zero)));

    p_cnt0_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel == CC_CNT0_NONNEG) |-> (cond_true == !cnt0[CNT_W-1]));

    p_rnd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_advance |-> (cond_valid && (cond_sel == CC_RND_ONE || cond_sel == CC_RND_ZERO)));

    p_rnd_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel == CC_RND_ONE) |-> (cond_true == rnd_bit));

    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_sel >= 5'd26) |-> (!cond_true && !rnd_advance));

endmodule

// File: tb/test_cond_eval_unit.sv
`timescale 1ns/1ps
module test_cond_eval_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cond_valid;
    logic [4:0]  cond_sel;
    logic [10:0] fl;   // 0 neg,1 zero,2 lovf,3 movf,4 all,5 none,6 some,7 notall,8 odd,9 m1,10 rnd
    logic        cnt_wr_en;
    logic [0:0]  cnt_wr_sel;
    logic [15:0] cnt_wr_data;
    logic        cond_true, rnd_advance;
    logic [15:0] cnt0, cnt1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] m0, m1;

    always #2.5 clk = ~clk;

    cond_eval_unit i_cond_eval_unit (
        .clk(clk), .rst_n(rst_n), .cond_valid(cond_valid), .cond_sel(cond_sel),
        .flag_neg(fl[0]), .flag_zero(fl[1]), .flag_lovf(fl[2]), .flag_movf(fl[3]),
        .bio_all(fl[4]), .bio_none(fl[5]), .bio_some(fl[6]), .bio_notall(fl[7]),
        .bmu_odd(fl[8]), .bmu_m1(fl[9]), .rnd_bit(fl[10]),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
        .cond_true(cond_true), .rnd_advance(rnd_advance), .cnt0(cnt0), .cnt1(cnt1)
    );

    function automatic bit exp_eval(bit v, int sel, logic [10:0] f, logic [15:0] c0, logic [15:0] c1);
        if (!v) return 1'b0;
        case (sel)
            0: return 1'b1;        1: return 1'b0;
            2: return !f[0];       3: return f[0];
            4: return f[1];        5: return !f[1];
            6: return !f[0] && !f[1];
            7: return f[0] || f[1];
            8: return f[2];        9: return !f[2];
            10: return f[3];       11: return !f[3];
            12: return !c0[15];    13: return c0[15];
            14: return !c1[15];    15: return c1[15];
            16: return f[10];      17: return !f[10];
            18: return f[4];       19: return f[5];
            20: return f[6];       21: return f[7];
            22: return f[8];       23: return !f[8];
            24: return f[9];       25: return !f[9];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int sel);
        if (sel <= 1)  return "R8";
        if (sel <= 7)  return (sel <= 5) ? "R1" : "R1";
        if (sel <= 11) return "R2";
        if (sel <= 15) return "R3";
        if (sel <= 17) return "R7";
        if (sel <= 21) return "R9";
        if (sel <= 25) return "R10";
        return "R11";
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int sel, logic [10:0] f, bit we, bit ws, logic [15:0] wd);
        int tested;
        bit e_hit, e_rnd;
        @(negedge clk);
        cond_valid = v; cond_sel = 5'(sel); fl = f;
        cnt_wr_en = we; cnt_wr_sel = ws; cnt_wr_data = wd;
        #1;
        e_hit = exp_eval(v, sel, f, m0, m1);
        e_rnd = v && (sel == 16 || sel == 17);
        chk(v ? tag_of(sel) : "R12", "cond_true", 32'(cond_true), 32'(e_hit));
        chk(v ? "R7" : "R12", "rnd_advance", 32'(rnd_advance), 32'(e_rnd));
        tested = (v && sel >= 12 && sel <= 15) ? ((sel <= 13) ? 0 : 1) : -1;
        if (tested == 0 && !(we && ws == 1'b0)) m0 = m0 + 16'd1;
        if (tested == 1 && !(we && ws == 1'b1)) m1 = m1 + 16'd1;
        if (we && ws == 1'b0) m0 = wd;
        if (we && ws == 1'b1) m1 = wd;
        @(posedge clk); #1;
        chk((we && ws == 1'b0) ? "R6" : (tested == 0 ? "R4" : (sel >= 26 ? "R11" : "R5")),
            "cnt0", 32'(cnt0), 32'(m0));
        chk((we && ws == 1'b1) ? "R6" : (tested == 1 ? "R4" : (sel >= 26 ? "R11" : "R5")),
            "cnt1", 32'(cnt1), 32'(m1));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cond_valid = 1'b0; cond_sel = '0; fl = '0;
        cnt_wr_en = 1'b0; cnt_wr_sel = '0; cnt_wr_data = '0;
        m0 = '0; m1 = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "reset cnt0", 32'(cnt0), 0);
        chk("R12", "reset cnt1", 32'(cnt1), 0);
        chk("R12", "idle cond_true", 32'(cond_true), 0);
        @(negedge clk); rst_n = 1'b1;

        // directed: sign boundary, load priority, wrap
        step(0, 0, '0, 1, 0, 16'h7FFF);        // R6 load
        step(1, 12, '0, 0, 0, 16'h0);          // R3 true on 7FFF, R4 -> 8000
        step(1, 13, '0, 0, 0, 16'h0);          // R3 true on 8000 -> 8001
        step(1, 12, '0, 1, 0, 16'hFFFF);       // R6 load wins over increment
        step(1, 13, '0, 0, 0, 16'h0);          // R4 FFFF wraps to 0000
        step(1, 14, '0, 1, 0, 16'h1234);       // c1 steps while c0 loads
        step(0, 12, 11'h7FF, 0, 0, 16'h0);     // R5 no effect when not evaluated
        for (int s = 26; s < 32; s++) step(1, s, 11'h7FF, 0, 0, 16'h0); // R11
        step(1, 16, 11'h400, 0, 0, 16'h0);     // R7 random one
        step(1, 17, 11'h400, 0, 0, 16'h0);     // R7 random zero fails
        step(1, 0, '0, 0, 0, 16'h0);           // R8
        step(1, 1, 11'h7FF, 0, 0, 16'h0);      // R8

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] wd;
            int pick;
            pick = int'($urandom % 4);
            wd = (pick == 0) ? 16'h7FFF : (pick == 1) ? 16'hFFFF :
                 (pick == 2) ? 16'h7FFE : 16'($urandom);
            step(($urandom % 4) != 0, int'($urandom % 32), 11'($urandom),
                 ($urandom % 6) == 0, 1'($urandom), wd);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule